// File: doc/BRIEF.md
# Two-Digit Decimal Counter

This block counts clock edges in decimal, from 00 up to 99, using two cascaded four-bit binary-coded-decimal digit stages. Each stage recognises its own terminal value 9 from only two bits of its code (bit 3 and bit 0 both set). On the next counting edge it reloads 0000 synchronously instead of stepping past 9.

That same terminal detection gates the count enable passed to the following stage. The tens digit therefore moves only on an edge where the units digit wraps. A synchronous clear returns both digits to zero and wins over counting. A combinational carry output marks the cycle in which an enabled count at 99 is about to roll over to 00. The packed output carries the units digit in bits [3:0] and the tens digit in bits [7:4].

Top module: `bcd_pair_counter`

## Requirements
- R1: While rst_n is low, bcd_o is 8'h00 and carry_o is 0; after release the count starts from 00.
- R2: With en_i high and clr_i low, a units digit (bcd_o[3:0]) below 9 increases by one on each rising clock edge.
- R3: A units digit at 9 (bit 3 and bit 0 both set) with en_i high and clr_i low is reloaded to 0 on the next edge.
- R4: The tens digit (bcd_o[7:4]) increments only on an edge where the units digit is 9, en_i is high and clr_i is low; on every other edge without clear it holds.
- R5: At 99 with en_i high and clr_i low, both digits return to 0 on the next edge.
- R6: carry_o is high exactly in a cycle where bcd_o is 8'h99, en_i is high and clr_i is low.
- R7: clr_i high on an edge loads 00 into both digits regardless of en_i; carry_o is low while clr_i is high.
- R8: With en_i low and clr_i low, both digits hold their values.
- R9: Counting from 00 with en_i held high visits 00, 01 … 09, 10 … 99 in decimal order and returns to 00 after 100 edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear to 00, priority over counting |
| en_i | input | 1 | Count enable |
| bcd_o | output | 8 | Count: tens digit in [7:4], units digit in [3:0] |
| carry_o | output | 1 | High in an enabled cycle at 99 |

## Verification
The bench drives the counter through the 09→10, 19→20 and 99→00 boundaries with enable held, pulsed and dropped. A units stage that did not reload at 9 would show hex codes A to F. A tens stage enabled from the raw enable instead of the cascaded one would advance every edge. Clear is applied together with enable, including at 99, so a design that let counting win, or raised carry during clear, is exposed. Long enable-low stretches at mid-count values catch a digit that drifts when it should hold.

// File: rtl/bcd_pair_counter.sv
module bcd_pair_counter #(
  parameter int DIGITS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic                  en_i,
  output logic [4*DIGITS-1:0]   bcd_o,
  output logic                  carry_o
);
  localparam int W = 4 * DIGITS;

  logic [DIGITS:0] step;

  assign step[0] = en_i;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    logic [3:0] dig;
    logic       at_nine;

    assign at_nine     = dig[3] & dig[0];
    assign step[i+1]   = step[i] & at_nine;
    assign bcd_o[4*i +: 4] = dig;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        dig <= 4'd0;
      else if (clr_i)
        dig <= 4'd0;
      else if (step[i])
        dig <= at_nine ? 4'd0 : dig + 4'd1;
    end
  end

  assign carry_o = step[DIGITS] & ~clr_i;

  logic [W-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: rtl/bcd_pair_counter_chk.sv
module bcd_pair_counter_chk #(
  parameter int DIGITS = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                clr_i,
  input logic                en_i,
  input logic [4*DIGITS-1:0] bcd_o,
  input logic                carry_o
);
  logic [3:0] u, t;
  assign u = bcd_o[3:0];
  assign t = bcd_o[7:4];

  a_r1_digits_decimal: assert property (@(posedge clk) disable iff (!rst_n)
    (u <= 4'd9) && (t <= 4'd9));

  a_r2_units_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && en_i && u < 4'd9) |=> (u == $past(u) + 4'd1));

  a_r3_units_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && en_i && u == 4'd9) |=> (u == 4'd0));

  a_r4_tens_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !(en_i && u == 4'd9)) |=> $stable(t));

  a_r5_full_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && en_i && u == 4'd9 && t == 4'd9) |=> (u == 4'd0 && t == 4'd0));

  a_r6_carry_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |-> (u == 4'd9 && t == 4'd9 && en_i && !clr_i));

  a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (u == 4'd0 && t == 4'd0));

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !en_i) |=> $stable(bcd_o));
endmodule

bind bcd_pair_counter bcd_pair_counter_chk #(.DIGITS(DIGITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .en_i(en_i),
  .bcd_o(bcd_o), .carry_o(carry_o)
);

// File: tb/tb_bcd_pair_counter.sv
`timescale 1ns/1ps
module tb_bcd_pair_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       en = 1'b0;
  logic [7:0] bcd;
  logic       carry;

  int checks = 0;
  int errors = 0;
  int cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bcd_pair_counter dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .en_i(en),
    .bcd_o(bcd), .carry_o(carry)
  );

  function automatic logic [7:0] enc(input int n);
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit c, input bit e);
    int    prev;
    string tag;
    @(negedge clk);
    clr = c;
    en  = e;
    #1;
    if (c)
      chk("R7 carry low in clear", {7'd0, carry}, 8'd0);
    else
      chk("R6 carry", {7'd0, carry}, {7'd0, (cnt == 99) && e});
    prev = cnt;
    @(posedge clk);
    #1;
    if (c)             begin cnt = 0;                tag = "R7 clear"; end
    else if (!e)       begin                         tag = "R8 hold"; end
    else if (prev == 99) begin cnt = 0;              tag = "R5 full wrap"; end
    else if (prev % 10 == 9) begin cnt = prev + 1;   tag = "R3 units wrap"; end
    else               begin cnt = prev + 1;         tag = "R2 units step"; end
    chk(tag, bcd, enc(cnt));
    if (!c && !(e && prev % 10 == 9))
      chk("R4 tens only on units wrap", {4'd0, bcd[7:4]}, {4'd0, 4'(prev / 10)});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset count", bcd, 8'h00);
    chk("R1 reset carry", {7'd0, carry}, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;
    cnt = 0;

    for (int i = 0; i < 100; i++) begin
      cyc(1'b0, 1'b1);
      if (i == 98) chk("R9 reaches 99", bcd, 8'h99);
    end
    chk("R9 back to 00 after 100", bcd, 8'h00);

    for (int i = 0; i < 37; i++) cyc(1'b0, 1'b1);
    for (int i = 0; i < 20; i++) cyc(1'b0, 1'b0);
    chk("R8 held at 37", bcd, 8'h37);

    for (int i = 0; i < 62; i++) cyc(1'b0, 1'b1);
    chk("R5 at 99", bcd, 8'h99);
    cyc(1'b1, 1'b1);
    chk("R7 clear at 99", bcd, 8'h00);

    for (int i = 0; i < 99; i++) cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b1);
    chk("R5 wrap after idle", bcd, 8'h00);

    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 15);
      cyc(r == 0, r > 4);
    end

    for (int i = 0; i < 19; i++) cyc(1'b0, 1'b1);
    cyc(1'b1, 1'b0);
    chk("R7 clear without enable", bcd, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule